// File: doc/BRIEF.md
# DMA Interrupt Status and Index Encoder

This block gathers every interrupt source of a multi-channel DMA engine into one sticky status vector and turns it into a single interrupt request. Each channel reports a one-cycle pulse when its block completes. The lower channels can also raise an early warning a chosen number of transfers before they finish. Two error inputs report a bad address and a bad data beat. Software can set or clear any flag and can write an enable mask. The block presents the raw flags, the enabled flags, an index code for the most urgent enabled source, and one interrupt line.

The early warning exists so that an interrupt handler can begin its context switch while the last transfers are still running. Each early-capable channel presents its live remaining-transfer count, the size it was loaded with, and a threshold selection. The flag is raised when the count reaches the selected level. Whatever their channel numbers, completion flags always rank above early flags in the index, so a handler that reads the index after the block has finished sees the completion first.

Top module: `dma_irq_index`

## Requirements
- R1: After reset the raw status, the enable mask, the enabled status, the index and the interrupt line are all zero.
- R2: Status bit k (0..15) is the completion flag of channel k. A pulse on `done_i[k]` sets it, and the flag is visible on the cycle after the pulse.
- R3: Bit 24 is the address-error flag, set by `addr_err_i`. Bit 25 is the data-error flag, set by `data_err_i`. Both are visible one cycle after the pulse.
- R4: `raw_o` shows every flag whether it is enabled or not. `masked_o` is `raw_o` AND the enable mask. A cycle with `mask_wr_i` high loads `mask_i` as the new mask.
- R5: `idx_o` is 0 when no enabled flag is set. Otherwise it is one plus the lowest set bit position of `masked_o`. The codes are: 1..16 for channel 0..15 complete, 17..24 for early 0..7, 25 for address error and 26 for data error.
- R6: While any enabled completion flag is set, `idx_o` is at most 16, even when early or error flags are pending.
- R7: `irq_o` is high exactly when at least one enabled flag is set, that is, exactly when `idx_o` is non-zero.
- R8: Flags stay set until software clears them. A cycle with `sw_clr_i[k]` high clears bit k on the next cycle.
- R9: If a set of a flag and a clear of the same flag happen in the same cycle, the flag ends up set. The set may come from `sw_set_i` or from a hardware source.
- R10: Early flag e (channels 0..7, status bit 16+e) sets on the cycle after `remain_i[e]` changes to a value equal to the selected level. The `thr_sel_i` codes are: 1→1, 2→2, 3→4, 4→8, 5→32, 6→64. After reset the previous count is taken as 0.
- R11: For `thr_sel_i` code 7 the level is `init_size_i[e]` shifted right by one.
- R12: For `thr_sel_i` code 0 the early flag never sets from the count, including when the count reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 16 | Per-channel block-complete pulses |
| addr_err_i | input | 1 | Address error pulse |
| data_err_i | input | 1 | Data error pulse |
| remain_i | input | 8x16 | Live remaining-transfer count of early-capable channels |
| init_size_i | input | 8x16 | Loaded block size of early-capable channels |
| thr_sel_i | input | 8x3 | Early threshold selection per channel |
| sw_set_i | input | 26 | Software set strobes, one per status bit |
| sw_clr_i | input | 26 | Software clear strobes, one per status bit |
| mask_wr_i | input | 1 | Enable-mask write strobe |
| mask_i | input | 26 | Enable-mask write value |
| raw_o | output | 26 | Raw sticky status |
| masked_o | output | 26 | Status AND enable mask |
| idx_o | output | 5 | Index code of the most urgent enabled flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every flag change is due exactly one cycle after its cause. This holds for a completion or error pulse, a software set or clear, a mask write, and an early count that reaches its level. `masked_o`, `idx_o` and `irq_o` follow combinationally from the registered flags and mask, so they are due in that same cycle. The bench drives each stimulus on a falling edge and holds it through one rising edge. It removes the stimulus and samples every output at the next falling edge, so each check lands in the single cycle in which the result first appears. The early-flag tests step the count down by one per cycle and compare the flag after every step, which pins the setting cycle exactly at the threshold.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;

    typedef enum logic [2:0] {
        THR_OFF  = 3'd0,
        THR_1    = 3'd1,
        THR_2    = 3'd2,
        THR_4    = 3'd3,
        THR_8    = 3'd4,
        THR_32   = 3'd5,
        THR_64   = 3'd6,
        THR_HALF = 3'd7
    } thr_sel_e;

    // Level at which the early flag fires; the half setting uses the loaded size
    function automatic logic [31:0] thr_level(input logic [2:0] sel, input logic [31:0] init_size);
        logic [31:0] lvl;
        case (thr_sel_e'(sel))
            THR_1:    lvl = 32'd1;
            THR_2:    lvl = 32'd2;
            THR_4:    lvl = 32'd4;
            THR_8:    lvl = 32'd8;
            THR_32:   lvl = 32'd32;
            THR_64:   lvl = 32'd64;
            THR_HALF: lvl = init_size >> 1;
            default:  lvl = 32'd0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/dma_early_detect.sv
`timescale 1ns/1ps
module dma_early_detect #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] remain_i,
    input  logic [CNT_W-1:0] init_size_i,
    input  logic [2:0]       thr_sel_i,
    output logic             hit_o
);
    import dma_irq_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] prev;
    } state_t;

    state_t      state_d, state_q;
    logic [31:0] level;
    logic [31:0] remain_ext;
    logic        enabled;
    logic        moved;

    always_comb begin
        state_d      = state_q;
        state_d.prev = remain_i;
        remain_ext   = 32'(remain_i);
        level        = thr_level(thr_sel_i, 32'(init_size_i));
        enabled      = (thr_sel_e'(thr_sel_i) != THR_OFF);
        moved        = (remain_i != state_q.prev);
        hit_o        = enabled && moved && (remain_ext == level);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dma_flag_bank.sv
`timescale 1ns/1ps
module dma_flag_bank #(
    parameter int NSRC = 26
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] hw_set_i,
    input  logic [NSRC-1:0] sw_set_i,
    input  logic [NSRC-1:0] sw_clr_i,
    input  logic            mask_wr_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] raw_o,
    output logic [NSRC-1:0] mask_o
);

    typedef struct packed {
        logic [NSRC-1:0] raw;
        logic [NSRC-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        // clear first, then any set source wins
        state_d.raw = (state_q.raw & ~sw_clr_i) | sw_set_i | hw_set_i;
        if (mask_wr_i) begin
            state_d.mask = mask_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign raw_o  = state_q.raw;
    assign mask_o = state_q.mask;

endmodule

// File: rtl/dma_idx_encoder.sv
`timescale 1ns/1ps
module dma_idx_encoder #(
    parameter int NSRC  = 26,
    parameter int IDX_W = 5
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        idx_o = '0;
        // scan downward so the lowest set position is the last written
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i + 1);
            end
        end
        any_o = |pend_i;
    end

endmodule

// File: rtl/dma_irq_index.sv
`timescale 1ns/1ps
module dma_irq_index #(
    parameter int NUM_CH    = 16,
    parameter int NUM_EARLY = 8,
    parameter int CNT_W     = 16,
    localparam int NSRC     = NUM_CH + NUM_EARLY + 2,
    localparam int IDX_W    = $clog2(NSRC + 1)
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [NUM_CH-1:0]                   done_i,
    input  logic                                addr_err_i,
    input  logic                                data_err_i,
    input  logic [NUM_EARLY-1:0][CNT_W-1:0]     remain_i,
    input  logic [NUM_EARLY-1:0][CNT_W-1:0]     init_size_i,
    input  logic [NUM_EARLY-1:0][2:0]           thr_sel_i,
    input  logic [NSRC-1:0]                     sw_set_i,
    input  logic [NSRC-1:0]                     sw_clr_i,
    input  logic                                mask_wr_i,
    input  logic [NSRC-1:0]                     mask_i,
    output logic [NSRC-1:0]                     raw_o,
    output logic [NSRC-1:0]                     masked_o,
    output logic [IDX_W-1:0]                    idx_o,
    output logic                                irq_o
);

    localparam int EARLY_LO = NUM_CH;
    localparam int ADDR_BIT = NUM_CH + NUM_EARLY;
    localparam int DATA_BIT = ADDR_BIT + 1;

    logic [NUM_EARLY-1:0] early_hit;
    logic [NSRC-1:0]      hw_set;
    logic [NSRC-1:0]      mask_q;

    for (genvar e = 0; e < NUM_EARLY; e++) begin : g_early
        dma_early_detect #(
            .CNT_W (CNT_W)
        ) u_det (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .remain_i    (remain_i[e]),
            .init_size_i (init_size_i[e]),
            .thr_sel_i   (thr_sel_i[e]),
            .hit_o       (early_hit[e])
        );
    end

    always_comb begin
        hw_set                              = '0;
        hw_set[NUM_CH-1:0]                  = done_i;
        hw_set[EARLY_LO +: NUM_EARLY]       = early_hit;
        hw_set[ADDR_BIT]                    = addr_err_i;
        hw_set[DATA_BIT]                    = data_err_i;
    end

    dma_flag_bank #(
        .NSRC (NSRC)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hw_set_i  (hw_set),
        .sw_set_i  (sw_set_i),
        .sw_clr_i  (sw_clr_i),
        .mask_wr_i (mask_wr_i),
        .mask_i    (mask_i),
        .raw_o     (raw_o),
        .mask_o    (mask_q)
    );

    assign masked_o = raw_o & mask_q;

    dma_idx_encoder #(
        .NSRC  (NSRC),
        .IDX_W (IDX_W)
    ) u_enc (
        .pend_i (masked_o),
        .idx_o  (idx_o),
        .any_o  (irq_o)
    );

endmodule

// File: rtl/dma_irq_index_chk.sv
`timescale 1ns/1ps
module dma_irq_index_chk #(
    parameter int NUM_CH    = 16,
    parameter int NUM_EARLY = 8,
    parameter int NSRC      = 26,
    parameter int IDX_W     = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] done_i,
    input logic              addr_err_i,
    input logic              data_err_i,
    input logic [NSRC-1:0]   sw_set_i,
    input logic [NSRC-1:0]   sw_clr_i,
    input logic [NSRC-1:0]   raw_o,
    input logic [NSRC-1:0]   masked_o,
    input logic [IDX_W-1:0]  idx_o,
    input logic              irq_o
);

    logic [NSRC-1:0] port_set;
    logic [NSRC-1:0] plain_bits;
    logic [NSRC-1:0] clr_only;
    logic            idx_ok;

    always_comb begin
        port_set                = '0;
        port_set[NUM_CH-1:0]    = done_i;
        port_set[NSRC-2]        = addr_err_i;
        port_set[NSRC-1]        = data_err_i;
        plain_bits              = '1;
        plain_bits[NUM_CH +: NUM_EARLY] = '0;
        clr_only                = sw_clr_i & ~sw_set_i & ~port_set & plain_bits;
        idx_ok                  = (idx_o == '0);
        for (int i = 0; i < NSRC; i++) begin
            if (idx_o == IDX_W'(i + 1)) begin
                idx_ok = masked_o[i] && ((masked_o & ((NSRC'(1) << i) - NSRC'(1))) == '0);
            end
        end
    end

    AST_SW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|sw_set_i) |=> ((raw_o & $past(sw_set_i)) == $past(sw_set_i))); // R9

    AST_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|port_set) |=> ((raw_o & $past(port_set)) == $past(port_set))); // R2

    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> ((~raw_o & $past(raw_o & ~sw_clr_i)) == '0)); // R8

    AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|clr_only) |=> ((raw_o & $past(clr_only)) == '0)); // R8

    AST_IRQ_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((idx_o == '0) == !irq_o)); // R7

    AST_IDX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_ok); // R5

    AST_DONE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|masked_o[NUM_CH-1:0]) |-> (idx_o <= IDX_W'(NUM_CH))); // R6

endmodule

bind dma_irq_index dma_irq_index_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_EARLY (NUM_EARLY),
    .NSRC      (NSRC),
    .IDX_W     (IDX_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done_i),
    .addr_err_i (addr_err_i),
    .data_err_i (data_err_i),
    .sw_set_i   (sw_set_i),
    .sw_clr_i   (sw_clr_i),
    .raw_o      (raw_o),
    .masked_o   (masked_o),
    .idx_o      (idx_o),
    .irq_o      (irq_o)
);

// File: tb/test_dma_irq_index.sv
`timescale 1ns/1ps
module test_dma_irq_index;

    localparam int NUM_CH    = 16;
    localparam int NUM_EARLY = 8;
    localparam int CNT_W     = 16;
    localparam int NSRC      = NUM_CH + NUM_EARLY + 2;
    localparam int IDX_W     = 5;

    logic                            clk_i = 1'b0;
    logic                            rst_ni = 1'b0;
    logic [NUM_CH-1:0]               done_i = '0;
    logic                            addr_err_i = 1'b0;
    logic                            data_err_i = 1'b0;
    logic [NUM_EARLY-1:0][CNT_W-1:0] remain_i = '0;
    logic [NUM_EARLY-1:0][CNT_W-1:0] init_size_i = '0;
    logic [NUM_EARLY-1:0][2:0]       thr_sel_i = '0;
    logic [NSRC-1:0]                 sw_set_i = '0;
    logic [NSRC-1:0]                 sw_clr_i = '0;
    logic                            mask_wr_i = 1'b0;
    logic [NSRC-1:0]                 mask_i = '0;
    logic [NSRC-1:0]                 raw_o;
    logic [NSRC-1:0]                 masked_o;
    logic [IDX_W-1:0]                idx_o;
    logic                            irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk_i = ~clk_i;

    dma_irq_index #(
        .NUM_CH    (NUM_CH),
        .NUM_EARLY (NUM_EARLY),
        .CNT_W     (CNT_W)
    ) i_dma_irq_index (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .done_i      (done_i),
        .addr_err_i  (addr_err_i),
        .data_err_i  (data_err_i),
        .remain_i    (remain_i),
        .init_size_i (init_size_i),
        .thr_sel_i   (thr_sel_i),
        .sw_set_i    (sw_set_i),
        .sw_clr_i    (sw_clr_i),
        .mask_wr_i   (mask_wr_i),
        .mask_i      (mask_i),
        .raw_o       (raw_o),
        .masked_o    (masked_o),
        .idx_o       (idx_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one cycle: stimulus already applied, clock it in, drop pulses, sample
    task automatic tick();
        @(negedge clk_i);
        done_i     = '0;
        addr_err_i = 1'b0;
        data_err_i = 1'b0;
        sw_set_i   = '0;
        sw_clr_i   = '0;
        mask_wr_i  = 1'b0;
    endtask

    task automatic clear_all();
        sw_clr_i = '1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1", "raw after reset", 64'(raw_o), 64'd0);
        chk("R1", "masked after reset", 64'(masked_o), 64'd0);
        chk("R1", "idx after reset", 64'(idx_o), 64'd0);
        chk("R1", "irq after reset", 64'(irq_o), 64'd0);
        done_i = 16'h0001;
        tick();
        chk("R1", "mask zero after reset hides flag", 64'(masked_o), 64'd0);
        chk("R4", "raw shows disabled flag", 64'(raw_o[0]), 64'd1);
        clear_all();
    endtask

    task automatic t_mask();
        mask_i    = ~(NSRC'(1) << 5);
        mask_wr_i = 1'b1;
        tick();
        done_i[5] = 1'b1;
        tick();
        chk("R4", "raw bit5 set while masked", 64'(raw_o[5]), 64'd1);
        chk("R4", "masked bit5 hidden", 64'(masked_o), 64'd0);
        chk("R7", "irq low with only masked flag", 64'(irq_o), 64'd0);
        chk("R5", "idx zero with only masked flag", 64'(idx_o), 64'd0);
        mask_i    = '1;
        mask_wr_i = 1'b1;
        tick();
        chk("R4", "mask write exposes bit5", 64'(masked_o), 64'(NSRC'(1) << 5));
        chk("R5", "idx for channel 5", 64'(idx_o), 64'd6);
        clear_all();
    endtask

    task automatic t_complete();
        done_i[3] = 1'b1;
        tick();
        chk("R2", "channel 3 flag", 64'(raw_o), 64'(NSRC'(1) << 3));
        chk("R5", "idx for channel 3", 64'(idx_o), 64'd4);
        chk("R7", "irq high", 64'(irq_o), 64'd1);
        tick();
        tick();
        chk("R8", "channel 3 flag sticky", 64'(raw_o[3]), 64'd1);
        sw_clr_i[3] = 1'b1;
        tick();
        chk("R8", "channel 3 cleared", 64'(raw_o), 64'd0);
        chk("R7", "irq low after clear", 64'(irq_o), 64'd0);
    endtask

    task automatic t_priority();
        done_i[15]   = 1'b1;
        sw_set_i[16] = 1'b1;
        addr_err_i   = 1'b1;
        data_err_i   = 1'b1;
        tick();
        chk("R3", "both error flags", 64'(raw_o[25:24]), 64'd3);
        chk("R6", "channel 15 above early 0", 64'(idx_o), 64'd16);
        sw_clr_i[15] = 1'b1;
        tick();
        chk("R5", "early 0 code", 64'(idx_o), 64'd17);
        sw_clr_i[16] = 1'b1;
        tick();
        chk("R3", "address error code", 64'(idx_o), 64'd25);
        sw_clr_i[24] = 1'b1;
        tick();
        chk("R3", "data error code", 64'(idx_o), 64'd26);
        sw_set_i[23] = 1'b1;
        done_i[9]    = 1'b1;
        tick();
        chk("R6", "channel 9 above early 7", 64'(idx_o), 64'd10);
        clear_all();
        chk("R5", "idx zero when empty", 64'(idx_o), 64'd0);
    endtask

    task automatic t_set_wins();
        sw_set_i[7] = 1'b1;
        sw_clr_i[7] = 1'b1;
        tick();
        chk("R9", "software set beats clear", 64'(raw_o[7]), 64'd1);
        done_i[7]   = 1'b1;
        sw_clr_i[7] = 1'b1;
        tick();
        chk("R9", "hardware set beats clear", 64'(raw_o[7]), 64'd1);
        clear_all();
    endtask

    task automatic t_early(input string req, input int ch, input logic [2:0] sel,
                           input int init, input int start, input int lvl);
        thr_sel_i[ch]   = sel;
        init_size_i[ch] = CNT_W'(init);
        for (int v = start; v >= 0; v--) begin
            remain_i[ch] = CNT_W'(v);
            tick();
            chk(req, $sformatf("early %0d flag at count %0d", ch, v),
                64'(raw_o[NUM_CH + ch]), 64'((lvl >= 0) && (v <= lvl)));
        end
        if (lvl >= 0) begin
            chk(req, "early code reported", 64'(idx_o), 64'(NUM_CH + ch + 1));
        end
        thr_sel_i[ch] = 3'd0;
        clear_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_mask();
        t_complete();
        t_priority();
        t_set_wins();
        t_early("R10", 2, 3'd3, 0, 10, 4);
        t_early("R10", 1, 3'd1, 0, 3, 1);
        t_early("R10", 5, 3'd6, 0, 70, 64);
        t_early("R11", 7, 3'd7, 20, 20, 10);
        t_early("R12", 0, 3'd0, 0, 5, -1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule